// File: doc/BRIEF.md
# HD Video Timing Flag Decoder

This block sits on the receive side of a high-definition video link. It takes an already word-aligned parallel stream, one 20-bit word per clock. The upper ten bits carry the luma channel and the lower ten bits carry the chroma channel. The block passes the stream through unchanged and adds four single-word status flags that line up with the data.

The flags mark three things in each line:
- the line-number word that follows end-of-active-video,
- the first line of a frame,
- the horizontal blanking words.

A fourth flag reports a mismatch between the received per-line CRC and the CRC computed locally for each channel.

Timing references are found with two words of lookahead. A state machine then walks the word that is about to leave the block. Its states are:
- `S_HUNT`: after reset; no reference seen yet, or the last one was invalid.
- `S_VIDEO`: after start-of-active-video.
- `S_Z0`, `S_Z1`, `S_XYZ`: the three words that follow a reference preamble.
- `S_LN0`, `S_LN1`: the two line-number words.
- `S_CRC0`, `S_CRC1`: the two CRC words.
- `S_HBLANK`: horizontal blanking.

Its transitions are:
- `S_HUNT`, `S_VIDEO` and `S_HBLANK` each go to `S_Z0` on a preamble and otherwise stay where they are.
- `S_Z0` always goes to `S_Z1`, and `S_Z1` always goes to `S_XYZ`.
- `S_XYZ` goes to `S_LN0` on a valid end code, to `S_VIDEO` on a valid start code, and to `S_HUNT` on an invalid code.
- `S_LN0`, `S_LN1`, `S_CRC0` and `S_CRC1` each step to the next in that order, and `S_CRC1` goes to `S_HBLANK`.

Top module: `hd_timing_flagger`

## Requirements
- R1: A word sampled on `din` at rising edge k appears on `dout` after rising edge k+3, and its four flags appear in that same cycle. While reset is asserted, `dout` is zero.
- R2: While reset is asserted all four flags are 0. After reset, no flag is raised before the first valid end-of-active-video reference.
- R3: A timing reference consists of the following, where "both halves" means both the luma half (bits 19:10) and the chroma half (bits 9:0):
  - a preamble of three words: 3FF in both halves, then 000 in both halves, then 000 in both halves;
  - a code word whose halves are equal and whose bit 9 is 1.
  
  Code bit 6 set to 1 marks end-of-active-video and bit 6 set to 0 marks start-of-active-video. A code word with bit 9 equal to 0 is invalid. After an invalid code, no flag is raised until a later valid reference.
- R4: `flag_line` is 1 for exactly one word, the second word after an end-of-active-video code word (the LN1 word).
- R5: `flag_frame` is 1 only on the LN1 word, and only when the line number is 1. The 11-bit line number is taken from the luma half: bits 8:2 of LN0 form bits 6:0, and bits 5:2 of LN1 form bits 10:7.
- R6: `flag_hanc` is 1 on every word from the one after CRC1 up to the word before the 3FF that opens the next reference, and is 0 on that 3FF.
- R7: Each half has its own 18-bit CRC, and `flag_crcerr` is 1 on the CRC1 word when either half mismatches. The CRC rules are:
  - Its coverage starts at 0 on the first word after a start-of-active-video code.
  - It takes each word bit by bit, LSB first. For each bit, with feedback f equal to CRC bit 0 XOR the data bit, the new CRC is the old one shifted right by one, XORed with 0x23000 when f is 1. This realises x^18+x^5+x^4+1.
  - Coverage runs through LN1, including the end-of-active-video reference.
  - The received value is compared as CRC1 bits 8:0 (high nine bits) joined with CRC0 bits 8:0 (low nine bits).
- R8: `flag_crcerr` stays 0 on a CRC1 word whose coverage did not begin at a start-of-active-video code seen since reset or since the previous CRC1.
- R9: `flag_line`, `flag_frame` and `flag_crcerr` are 0 on every word other than the ones named in R4, R5 and R7. `flag_hanc` is 0 on active video and on reference, line-number and CRC words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Incoming word: luma in 19:10, chroma in 9:0 |
| dout | output | 20 | Delayed copy of `din`, aligned with the flags |
| flag_line | output | 1 | High on the LN1 word |
| flag_frame | output | 1 | High on the LN1 word of line 1 |
| flag_hanc | output | 1 | High on horizontal blanking words |
| flag_crcerr | output | 1 | High on CRC1 when the line CRC mismatches |

## Verification
The assertions assume that the stream respects the word order of a line. Every end-of-active-video reference is followed by LN0, LN1, CRC0 and CRC1, and no data, line-number or CRC word ever takes the reserved values 3FF or 000, so a preamble can only appear where a reference begins. The stimulus keeps within this in three ways:
- Active and blanking samples are drawn from the range 010 to 3EF.
- Line-number and CRC words always carry bit 9 as the inverse of bit 8.
- The deliberately invalid reference uses a code word with bit 9 cleared, so its preamble is still legal.

// File: rtl/hdtf_pkg.sv
package hdtf_pkg;

    localparam int LANE_W   = 10;
    localparam int CRC_W    = 18;
    localparam int CRC_HALF = CRC_W / 2;
    localparam int LN_LO_W  = 7;
    localparam int LN_HI_W  = 4;
    localparam int LN_W     = LN_LO_W + LN_HI_W;
    localparam logic [CRC_W-1:0] CRC_TAPS = 18'h23000;

    typedef enum logic [3:0] {
        S_HUNT,
        S_VIDEO,
        S_Z0,
        S_Z1,
        S_XYZ,
        S_LN0,
        S_LN1,
        S_CRC0,
        S_CRC1,
        S_HBLANK
    } hdtf_state_e;

    // one lane word folded into the CRC, least significant bit first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [LANE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < LANE_W; i++) begin
            fb = r[0] ^ d[i];
            r  = (r >> 1) ^ (fb ? CRC_TAPS : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdtf_word_delay.sv
module hdtf_word_delay #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WIDTH-1:0]             din,
    output logic [DEPTH-1:0][WIDTH-1:0]  taps
);

    // taps[0] is the newest word, taps[DEPTH-1] the oldest
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps <= '0;
        else        taps <= {taps[DEPTH-2:0], din};
    end

endmodule

// File: rtl/hdtf_crc_lane.sv
module hdtf_crc_lane
    import hdtf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              cap,
    input  logic              chk,
    input  logic [LANE_W-1:0] word,
    output logic              mismatch
);

    logic [CRC_W-1:0]    acc;
    logic [CRC_HALF-1:0] rx_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            rx_lo <= '0;
        end else begin
            if (clr)      acc <= '0;
            else if (upd) acc <= crc_step(acc, word);
            if (cap)      rx_lo <= word[CRC_HALF-1:0];
        end
    end

    assign mismatch = chk && ({word[CRC_HALF-1:0], rx_lo} != acc);

    // R7: the compare word always follows the capture of the low half
    a_r7_check_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        chk |-> $past(cap));

endmodule

// File: rtl/hd_timing_flagger.sv
module hd_timing_flagger
    import hdtf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*LANE_W-1:0]   din,
    output logic [2*LANE_W-1:0]   dout,
    output logic                  flag_line,
    output logic                  flag_frame,
    output logic                  flag_hanc,
    output logic                  flag_crcerr
);

    localparam int WORD_W = 2 * LANE_W;
    localparam int LOOK   = 3;
    localparam int N_LANE = 2;
    localparam logic [LANE_W-1:0] TRS_ONES  = '1;
    localparam logic [LN_W-1:0]   LINE_FIRST = LN_W'(1);

    logic [LOOK-1:0][WORD_W-1:0] taps;
    logic [WORD_W-1:0] cur, nxt1, nxt2;
    logic [LANE_W-1:0] luma, chroma;
    logic              trs_start, xyz_ok, is_eav;
    hdtf_state_e       state, state_nx;
    logic              armed;
    logic [LN_LO_W-1:0] ln_lo;
    logic [LN_W-1:0]   line_no;
    logic              lane_clr, lane_upd, lane_cap, lane_chk;
    logic [N_LANE-1:0] lane_mis;

    hdtf_word_delay #(.WIDTH(WORD_W), .DEPTH(LOOK)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .taps  (taps)
    );

    assign cur    = taps[LOOK-1];
    assign nxt1   = taps[LOOK-2];
    assign nxt2   = taps[LOOK-3];
    assign luma   = cur[WORD_W-1:LANE_W];
    assign chroma = cur[LANE_W-1:0];

    assign trs_start = (cur == {TRS_ONES, TRS_ONES}) && (nxt1 == '0) && (nxt2 == '0);
    assign xyz_ok    = (luma == chroma) && luma[LANE_W-1];
    assign is_eav    = luma[6];
    assign line_no   = {luma[LN_HI_W+1:2], ln_lo};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HUNT:   state_nx = trs_start ? S_Z0 : S_HUNT;
            S_VIDEO:  state_nx = trs_start ? S_Z0 : S_VIDEO;
            S_Z0:     state_nx = S_Z1;
            S_Z1:     state_nx = S_XYZ;
            S_XYZ:    state_nx = !xyz_ok ? S_HUNT : (is_eav ? S_LN0 : S_VIDEO);
            S_LN0:    state_nx = S_LN1;
            S_LN1:    state_nx = S_CRC0;
            S_CRC0:   state_nx = S_CRC1;
            S_CRC1:   state_nx = S_HBLANK;
            S_HBLANK: state_nx = trs_start ? S_Z0 : S_HBLANK;
            default:  state_nx = S_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= state_nx;
    end

    // CRC lane controls
    always_comb begin
        lane_clr = (state == S_XYZ) && xyz_ok && !is_eav;
        lane_upd = armed && ((state == S_VIDEO) || (state == S_Z0) || (state == S_Z1) ||
                             (state == S_LN0) || (state == S_LN1) ||
                             ((state == S_XYZ) && xyz_ok && is_eav));
        lane_cap = (state == S_CRC0);
        lane_chk = (state == S_CRC1);
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        hdtf_crc_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (lane_clr),
            .upd      (lane_upd),
            .cap      (lane_cap),
            .chk      (lane_chk),
            .word     (cur[g*LANE_W +: LANE_W]),
            .mismatch (lane_mis[g])
        );
    end

    // outputs and per-line context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout        <= '0;
            flag_line   <= 1'b0;
            flag_frame  <= 1'b0;
            flag_hanc   <= 1'b0;
            flag_crcerr <= 1'b0;
            armed       <= 1'b0;
            ln_lo       <= '0;
        end else begin
            dout        <= cur;
            flag_line   <= (state == S_LN1);
            flag_frame  <= (state == S_LN1) && (line_no == LINE_FIRST);
            flag_hanc   <= (state == S_HBLANK) && !trs_start;
            flag_crcerr <= (state == S_CRC1) && armed && (|lane_mis);
            if (state == S_LN0) ln_lo <= luma[LN_LO_W+1:2];
            if (state == S_XYZ) begin
                if (!xyz_ok)      armed <= 1'b0;
                else if (!is_eav) armed <= 1'b1;
            end else if (state == S_CRC1) begin
                armed <= 1'b0;
            end
        end
    end

    // R4: the line marker never lasts two words
    a_r4_line_single: assert property (@(posedge clk) disable iff (!rst_n)
        flag_line |=> !flag_line);

    // R5: frame marker only together with the line marker
    a_r5_frame_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        flag_frame |-> flag_line);

    // R7: CRC error lands two words after the line marker
    a_r7_crcerr_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        flag_crcerr |-> $past(flag_line, 2));

    // R9: blanking flag never coincides with the trailer flags
    a_r9_hanc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hanc |-> !flag_line && !flag_frame && !flag_crcerr);

endmodule

// File: tb/hd_timing_flagger_tb.sv
module hd_timing_flagger_tb;

    localparam int WW = 20;
    localparam int NL = 60;
    localparam logic [17:0] TAPS = 18'h23000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          flag_line, flag_frame, flag_hanc, flag_crcerr;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hd_timing_flagger u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .dout        (dout),
        .flag_line   (flag_line),
        .flag_frame  (flag_frame),
        .flag_hanc   (flag_hanc),
        .flag_crcerr (flag_crcerr)
    );

    // expected stream; kind: 0 other, 1 LN1, 2 CRC1 armed, 3 CRC1 unarmed,
    // 4 blanking, 5 before first reference, 6 invalid-reference line
    logic [WW-1:0] sw[$];
    bit sl[$], sf[$], sh[$], se[$];
    int sk[$];
    logic [17:0] cy, cc;
    bit armed, dirty;

    function automatic logic [17:0] bcrc(input logic [17:0] c, input logic [9:0] d);
        logic [17:0] r = c;
        for (int i = 0; i < 10; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ TAPS;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [9:0] sample(input int x);
        return 10'(16 + (x % 992));
    endfunction

    function automatic int line_no(input int l);
        case (l % 6)
            0: return 1;
            1: return 2;
            2: return 1025;
            3: return 129;
            4: return 1;
            default: return (l * 37) % 2048;
        endcase
    endfunction

    task automatic put(input logic [9:0] y, input logic [9:0] c, input bit l, input bit f,
                       input bit h, input bit e, input int kind, input bit cov);
        if (cov) begin
            cy = bcrc(cy, y);
            cc = bcrc(cc, c);
        end
        sw.push_back({y, c});
        sl.push_back(l); sf.push_back(f); sh.push_back(h); se.push_back(e);
        sk.push_back(kind);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string gen_tag(input int kind);
        case (kind)
            5: return "R2";
            6: return "R3";
            default: return "R9";
        endcase
    endfunction

    task automatic build();
        armed = 0; dirty = 0; cy = '0; cc = '0;
        for (int k = 0; k < 5; k++) put(10'h040, 10'h200, 0, 0, 0, 0, 5, 0);
        for (int k = 0; k < 4; k++) put(sample(k * 71), sample(k * 13 + 5), 0, 0, 0, 0, 5, 0);
        for (int l = 0; l < NL; l++) begin
            int ln = line_no(l);
            logic [10:0] lb = 11'(ln);
            bit bad = (l % 9 == 5);
            int m = (l == 0) ? 1 : (l % 5);
            logic [9:0] xyz = bad ? 10'h0F4 : 10'h274;
            int k0 = bad ? 6 : 0;
            bit cov = armed && !bad;
            logic [9:0] ln0 = {~lb[6], lb[6:0], 2'b00};
            logic [9:0] ln1 = {4'b1000, lb[10:7], 2'b00};
            logic [9:0] y0, y1, c0, c1;
            bit err;
            int nb, na;
            put(10'h3FF, 10'h3FF, 0, 0, 0, 0, k0, cov);
            put(10'h000, 10'h000, 0, 0, 0, 0, k0, cov);
            put(10'h000, 10'h000, 0, 0, 0, 0, k0, cov);
            put(xyz, xyz, 0, 0, 0, 0, k0, cov);
            put(ln0, ln0, 0, 0, 0, 0, k0, cov);
            put(ln1, ln1, !bad, !bad && (ln == 1), 0, 0, bad ? 6 : 1, cov);
            y0 = {~cy[8], cy[8:0]};   c0 = {~cc[8], cc[8:0]};
            y1 = {~cy[17], cy[17:9]}; c1 = {~cc[17], cc[17:9]};
            if (m == 1) y0[0] = ~y0[0];
            if (m == 2) c1[1] = ~c1[1];
            err = armed && !bad && (m == 1 || m == 2 || dirty);
            put(y0, c0, 0, 0, 0, 0, k0, 0);
            put(y1, c1, 0, 0, 0, err, bad ? 6 : (armed ? 2 : 3), 0);
            armed = 0; dirty = 0;
            nb = 1 + l % 4;
            for (int k = 0; k < nb; k++)
                put(sample(l * 7 + k * 3), sample(l * 11 + k), 0, 0, !bad, 0, bad ? 6 : 4, 0);
            put(10'h3FF, 10'h3FF, 0, 0, 0, 0, bad ? 6 : 4, 0);
            put(10'h000, 10'h000, 0, 0, 0, 0, 0, 0);
            put(10'h000, 10'h000, 0, 0, 0, 0, 0, 0);
            put(10'h200, 10'h200, 0, 0, 0, 0, 0, 0);
            armed = 1; cy = '0; cc = '0;
            na = 3 + l % 5;
            for (int k = 0; k < na; k++) begin
                logic [9:0] y = sample(l * 53 + k * 97);
                logic [9:0] c = sample(l * 29 + k * 61 + 500);
                if (l % 7 == 3 && k == 0) begin
                    cy = bcrc(cy, y);
                    cc = bcrc(cc, c);
                    put(y ^ 10'h008, c, 0, 0, 0, 0, 0, 0);
                    dirty = 1;
                end else begin
                    put(y, c, 0, 0, 0, 0, 0, 1);
                end
            end
        end
        for (int k = 0; k < 3; k++) put(sample(k + 9), sample(k + 19), 0, 0, 0, 0, 0, 1);
    endtask

    task automatic check_word(input int i);
        int k = sk[i];
        string tl = (k == 1) ? "R4" : gen_tag(k);
        string tf = (k == 1) ? "R5" : gen_tag(k);
        string th = (k == 4) ? "R6" : gen_tag(k);
        string te = (k == 2) ? "R7" : (k == 3) ? "R8" : gen_tag(k);
        chk(dout == sw[i], "R1", $sformatf("dout word %0d", i), dout, sw[i]);
        chk(flag_line == sl[i], tl, $sformatf("flag_line word %0d", i), WW'(flag_line), WW'(sl[i]));
        chk(flag_frame == sf[i], tf, $sformatf("flag_frame word %0d", i), WW'(flag_frame), WW'(sf[i]));
        chk(flag_hanc == sh[i], th, $sformatf("flag_hanc word %0d", i), WW'(flag_hanc), WW'(sh[i]));
        chk(flag_crcerr == se[i], te, $sformatf("flag_crcerr word %0d", i), WW'(flag_crcerr), WW'(se[i]));
    endtask

    initial begin
        build();
        repeat (4) begin
            @(negedge clk);
            chk({dout, flag_line, flag_frame, flag_hanc, flag_crcerr} == '0, "R2",
                "outputs in reset", WW'(dout), '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < sw.size() + 4; j++) begin
            @(negedge clk);
            if (j >= 4) check_word(j - 4);
            din = (j < sw.size()) ? sw[j] : {10'h040, 10'h040};
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got %0d cycles expected completion", 200000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule